// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It captures incoming requests into a pending set, either on rising edges or by following the input levels, and drops any request whose mask bit is set. Pending requests are ranked against the levels already in service under a priority order that can be rotated. When an eligible request outranks everything in service, the block raises `intr`. An acknowledge, or a poll, moves the winning level from pending to in service and returns a vector equal to a base value plus the level number.

Software-level control reaches the block as a 3-bit command with a 3-bit level argument. The commands end service on a level, either a named one or the top-ranked one, with or without rotating the order. A command can also choose the lowest-ranked level directly, and one pair of commands turns rotation on acknowledge on and off. An automatic end-of-service input skips the in-service step at acknowledge. A special mask input stops in-service levels from blocking lower-ranked requests. Decoding of the command words, cascade signalling and the host bus interface belong to neighbouring blocks.

Top module: `irq_resolver`

## Requirements
- R1: After reset the pending set and the in-service set are empty and `intr` is low. Level 0 ranks highest and level 7 lowest.
- R2: In edge mode (`level_mode`=0) a pending bit is set one clock after a rising input edge. It stays set after the input falls, until that level is acknowledged. In level mode the pending set copies `req_in` one clock later.
- R3: `intr` is high only when an unmasked pending request ranks above every in-service level. A request whose `mask` bit is 1 is ignored until the mask bit is cleared.
- R4: On `ack`, the winning level leaves the pending set and enters the in-service set. One clock later `vec_valid` pulses and `vec_out` = VEC_BASE + level. VEC_BASE defaults to 0x20.
- R5: An `ack` with no eligible request returns VEC_BASE + 7 and leaves the pending and in-service sets unchanged.
- R6: Command 001 clears the highest-ranked in-service bit. Command 011 clears the in-service bit given by `cmd_level`.
- R7: Command 110 makes `cmd_level` the lowest-ranked level. Command 111 clears that in-service bit and makes it lowest. Command 101 clears the highest-ranked in-service bit and makes that level lowest. Ranks then follow upward from the level just above the lowest, wrapping modulo 8.
- R8: Command 010 changes nothing. Command 100 turns on rotation on acknowledge, and command 000 turns it off.
- R9: With `auto_eoi` high, an acknowledge does not set an in-service bit. If rotation on acknowledge is on, the acknowledged level becomes lowest-ranked.
- R10: With `special_mask` high, in-service levels do not block other levels. Only masked levels, and levels that are themselves in service, are excluded.
- R11: A `poll` acknowledges the winner as `ack` does. One clock later `poll_valid` pulses with `poll_data`, where bit 7 = 1 if there was a winner, bits 2:0 = the level, and all other bits are 0. With no winner the word is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 8 | Interrupt request lines, one per level |
| level_mode | input | 1 | 1 = level-sensitive requests, 0 = edge-captured |
| mask | input | 8 | 1 = level masked |
| special_mask | input | 1 | In-service levels do not block lower-ranked levels |
| auto_eoi | input | 1 | Acknowledge ends service at once |
| ack | input | 1 | Acknowledge pulse, one clock |
| poll | input | 1 | Poll pulse, one clock |
| cmd_valid | input | 1 | Command strobe, one clock |
| cmd | input | 3 | Command code |
| cmd_level | input | 3 | Level argument of the command |
| intr | output | 1 | Interrupt request toward the processor |
| vec_valid | output | 1 | Vector returned, one-clock pulse |
| vec_out | output | 8 | Vector number |
| poll_valid | output | 1 | Poll word returned, one-clock pulse |
| poll_data | output | 8 | Poll word |
| irr_o | output | 8 | Pending request set |
| isr_o | output | 8 | In-service set |

## Verification
The assertions assume that `ack`, `poll` and `cmd_valid` are single-clock strobes, and that a command never arrives in the same cycle as an acknowledge. The ordering between those two sources is left undefined. They also assume `level_mode` changes only while no acknowledge is in flight. The stimulus keeps to these rules: every strobe is driven for one clock, with idle clocks between operations. Each request is a one-clock pulse, so no stale high input creates a second edge. The mode changes only once, at the end of the run, with the in-service set empty.

// File: rtl/irq_res_pkg.sv
// Package irq_res_pkg
// Shared sizing and command encoding for the interrupt resolver.
// Assumes the level count is a power of two, so that rank arithmetic wraps.
package irq_res_pkg;

    localparam int IRQ_COUNT = 8;
    localparam int IRQ_LW    = $clog2(IRQ_COUNT);

    // Command codes; the values are fixed by the neighbouring decoder.
    typedef enum logic [2:0] {
        CMD_AROT_OFF    = 3'b000,
        CMD_EOI_TOP     = 3'b001,
        CMD_IDLE        = 3'b010,
        CMD_EOI_LVL     = 3'b011,
        CMD_AROT_ON     = 3'b100,
        CMD_EOI_TOP_ROT = 3'b101,
        CMD_SET_LOWEST  = 3'b110,
        CMD_EOI_LVL_ROT = 3'b111
    } irq_cmd_e;

endpackage

// File: rtl/irq_request_reg.sv
// Module irq_request_reg
// Holds the pending request set. In edge mode a bit is set on a rising input
// and kept until the acknowledge path clears it. In level mode the set copies
// the inputs. Assumes level_mode is quasi-static.
module irq_request_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level_mode,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] irr_q;
    logic [N-1:0] rise;

    // Detect rising input edges against the previous sample.
    always_comb rise = req_in & ~prev_q;

    // Update the input history and the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= req_in;
            if (level_mode)
                irr_q <= req_in;
            else
                irr_q <= (irr_q & ~clr) | rise;
        end
    end

    assign irr_o = irr_q;

    // R2: in edge mode a pending bit only disappears when it is cleared.
    a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !level_mode |=> (($past(irr_q) & ~$past(clr) & ~irr_q) == '0));

endmodule

// File: rtl/irq_prio_resolve.sv
// Module irq_prio_resolve
// Combinational ranking. The rank order starts just above low_ptr and wraps
// modulo N. Returns the eligible winner and the top-ranked in-service level.
// Assumes N is a power of two.
module irq_prio_resolve #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr,
    input  logic [N-1:0]  isr,
    input  logic [N-1:0]  mask,
    input  logic          smm,
    input  logic [LW-1:0] low_ptr,
    output logic          win_valid,
    output logic [LW-1:0] win_lvl,
    output logic          svc_any,
    output logic [LW-1:0] svc_top
);

    logic [N-1:0] cand;

    // Requests that may compete: unmasked, and not in service in special mask mode.
    always_comb cand = irr & ~mask & (smm ? ~isr : {N{1'b1}});

    // Scan levels from highest to lowest rank to pick the winner and the top in-service level.
    always_comb begin
        logic [LW-1:0] lvl;
        logic          blocked;
        win_valid = 1'b0;
        win_lvl   = '0;
        svc_any   = 1'b0;
        svc_top   = '0;
        blocked   = 1'b0;
        lvl       = '0;
        for (int r = 0; r < N; r++) begin
            lvl = low_ptr + LW'(r + 1);
            if (isr[lvl] && !svc_any) begin
                svc_any = 1'b1;
                svc_top = lvl;
            end
            if (isr[lvl] && !smm)
                blocked = 1'b1;
            if (!blocked && !win_valid && cand[lvl]) begin
                win_valid = 1'b1;
                win_lvl   = lvl;
            end
        end
    end

endmodule

// File: rtl/irq_service_ctrl.sv
// Module irq_service_ctrl
// Owns the in-service set, the lowest-rank pointer and the rotate-on-ack flag.
// Applies acknowledges and commands. Assumes a command and an acknowledge do
// not arrive in the same cycle. If they do, the command's edits win.
module irq_service_ctrl
    import irq_res_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          win_valid,
    input  logic [LW-1:0] win_lvl,
    input  logic          auto_eoi,
    input  logic          cmd_valid,
    input  irq_cmd_e      cmd,
    input  logic [LW-1:0] cmd_level,
    input  logic          svc_any,
    input  logic [LW-1:0] svc_top,
    output logic [N-1:0]  isr_o,
    output logic [LW-1:0] low_ptr_o
);

    logic [N-1:0]  isr_q, isr_n;
    logic [LW-1:0] lp_q, lp_n;
    logic          arot_q, arot_n;

    // Next-state decode for acknowledges and commands.
    always_comb begin
        isr_n  = isr_q;
        lp_n   = lp_q;
        arot_n = arot_q;
        if (take && win_valid) begin
            if (!auto_eoi)
                isr_n[win_lvl] = 1'b1;
            else if (arot_q)
                lp_n = win_lvl;
        end
        if (cmd_valid) begin
            unique case (cmd)
                CMD_AROT_OFF:    arot_n = 1'b0;
                CMD_AROT_ON:     arot_n = 1'b1;
                CMD_IDLE:        ;
                CMD_EOI_TOP:     if (svc_any) isr_n[svc_top] = 1'b0;
                CMD_EOI_TOP_ROT: if (svc_any) begin
                                     isr_n[svc_top] = 1'b0;
                                     lp_n           = svc_top;
                                 end
                CMD_EOI_LVL:     isr_n[cmd_level] = 1'b0;
                CMD_EOI_LVL_ROT: begin
                                     isr_n[cmd_level] = 1'b0;
                                     lp_n             = cmd_level;
                                 end
                CMD_SET_LOWEST:  lp_n = cmd_level;
            endcase
        end
    end

    // State registers; after reset level N-1 is lowest-ranked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q  <= '0;
            lp_q   <= LW'(N - 1);
            arot_q <= 1'b0;
        end else begin
            isr_q  <= isr_n;
            lp_q   <= lp_n;
            arot_q <= arot_n;
        end
    end

    assign isr_o     = isr_q;
    assign low_ptr_o = lp_q;

    // R4: a plain acknowledge puts the winner in service.
    a_r4_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        take && win_valid && !auto_eoi && !cmd_valid |=> isr_q[$past(win_lvl)]);

    // R5: an acknowledge without a winner leaves the in-service set alone.
    a_r5_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        take && !win_valid && !cmd_valid |=> isr_q == $past(isr_q));

    // R9: automatic end-of-service never adds an in-service bit.
    a_r9_auto_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
        take && auto_eoi && !cmd_valid |=> isr_q == $past(isr_q));

    // R6: the top-ranked in-service level is cleared by the non-specific command.
    a_r6_top_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd == CMD_EOI_TOP && svc_any && !take |=> !isr_q[$past(svc_top)]);

    // R7: setting the lowest level lands in the pointer.
    a_r7_set_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd == CMD_SET_LOWEST |=> lp_q == $past(cmd_level));

endmodule

// File: rtl/irq_resolver.sv
// Module irq_resolver
// Top of the resolution core: request capture, rotating rank resolution,
// service tracking, and registered vector and poll results.
// Assumes ack, poll and cmd_valid are single-clock strobes.
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter int          NUM_IRQ  = IRQ_COUNT,
    parameter int          VEC_W    = 8,
    parameter logic [7:0]  VEC_BASE = 8'h20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IRQ-1:0]         req_in,
    input  logic                       level_mode,
    input  logic [NUM_IRQ-1:0]         mask,
    input  logic                       special_mask,
    input  logic                       auto_eoi,
    input  logic                       ack,
    input  logic                       poll,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd,
    input  logic [$clog2(NUM_IRQ)-1:0] cmd_level,
    output logic                       intr,
    output logic                       vec_valid,
    output logic [VEC_W-1:0]           vec_out,
    output logic                       poll_valid,
    output logic [7:0]                 poll_data,
    output logic [NUM_IRQ-1:0]         irr_o,
    output logic [NUM_IRQ-1:0]         isr_o
);

    localparam int LW     = $clog2(NUM_IRQ);
    localparam int POLL_W = 8;

    logic [NUM_IRQ-1:0] irr, isr, clr;
    logic               win_valid, svc_any, take;
    logic [LW-1:0]      win_lvl, svc_top, low_ptr;
    logic               vec_valid_q, poll_valid_q;
    logic [VEC_W-1:0]   vec_q;
    logic [POLL_W-1:0]  poll_q;

    // An acknowledge or a poll takes the current winner.
    always_comb take = ack | poll;

    // Clear mask for the pending bit of the level being taken.
    always_comb begin
        clr = '0;
        if (take && win_valid)
            clr[win_lvl] = 1'b1;
    end

    irq_request_reg #(.N(NUM_IRQ)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (level_mode),
        .req_in     (req_in),
        .clr        (clr),
        .irr_o      (irr)
    );

    irq_prio_resolve #(.N(NUM_IRQ), .LW(LW)) u_prio (
        .irr       (irr),
        .isr       (isr),
        .mask      (mask),
        .smm       (special_mask),
        .low_ptr   (low_ptr),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .svc_any   (svc_any),
        .svc_top   (svc_top)
    );

    irq_service_ctrl #(.N(NUM_IRQ), .LW(LW)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .auto_eoi  (auto_eoi),
        .cmd_valid (cmd_valid),
        .cmd       (irq_cmd_e'(cmd)),
        .cmd_level (cmd_level),
        .svc_any   (svc_any),
        .svc_top   (svc_top),
        .isr_o     (isr),
        .low_ptr_o (low_ptr)
    );

    // Register the vector and poll results one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_q  <= 1'b0;
            poll_valid_q <= 1'b0;
            vec_q        <= '0;
            poll_q       <= '0;
        end else begin
            vec_valid_q  <= ack;
            poll_valid_q <= poll;
            if (ack)
                vec_q <= win_valid ? VEC_W'(VEC_BASE) + VEC_W'(win_lvl)
                                   : VEC_W'(VEC_BASE) + VEC_W'(NUM_IRQ - 1);
            if (poll)
                poll_q <= win_valid ? {1'b1, {(POLL_W - 1 - LW){1'b0}}, win_lvl}
                                    : '0;
        end
    end

    assign intr       = win_valid;
    assign vec_valid  = vec_valid_q;
    assign vec_out    = vec_q;
    assign poll_valid = poll_valid_q;
    assign poll_data  = poll_q;
    assign irr_o      = irr;
    assign isr_o      = isr;

    // R3: the interrupt needs an unmasked pending request behind it.
    a_r3_intr_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (irr & ~mask) != '0);

    // R10: outside special mask mode a winner is never a level already in service.
    a_r10_winner_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        intr && !special_mask |-> !isr[win_lvl]);

    // R11: the unused middle bits of the poll word stay zero.
    a_r11_poll_padding: assert property (@(posedge clk) disable iff (!rst_n)
        poll_valid |-> poll_data[POLL_W-2:LW] == '0);

endmodule

// File: tb/test_irq_resolver.sv
// Scoreboard bench: driver tasks queue expected results, a monitor compares them.
module test_irq_resolver;

    localparam int         N    = 8;
    localparam logic [7:0] BASE = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0, mask = '0;
    logic       level_mode = 1'b0, special_mask = 1'b0, auto_eoi = 1'b0;
    logic       ack = 1'b0, poll = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cmd = '0, cmd_level = '0;
    logic       intr, vec_valid, poll_valid;
    logic [7:0] vec_out, poll_data, irr_o, isr_o;

    always #2 clk = ~clk;

    irq_resolver #(.NUM_IRQ(N), .VEC_W(8), .VEC_BASE(BASE)) i_irq_resolver (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .level_mode(level_mode),
        .mask(mask), .special_mask(special_mask), .auto_eoi(auto_eoi),
        .ack(ack), .poll(poll), .cmd_valid(cmd_valid), .cmd(cmd),
        .cmd_level(cmd_level), .intr(intr), .vec_valid(vec_valid),
        .vec_out(vec_out), .poll_valid(poll_valid), .poll_data(poll_data),
        .irr_o(irr_o), .isr_o(isr_o)
    );

    int         n_chk = 0, n_bad = 0;
    logic [8:0] exp_q[$];
    logic [8:0] got_item, exp_item;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse(logic [7:0] b);
        tick(); req_in = req_in | b;
        tick(); req_in = req_in & ~b;
    endtask

    task automatic do_ack(logic [7:0] v);
        tick(); ack = 1'b1; exp_q.push_back({1'b0, v});
        tick(); ack = 1'b0;
    endtask

    task automatic do_poll(logic [7:0] v);
        tick(); poll = 1'b1; exp_q.push_back({1'b1, v});
        tick(); poll = 1'b0;
    endtask

    task automatic send(logic [2:0] c, logic [2:0] l);
        tick(); cmd_valid = 1'b1; cmd = c; cmd_level = l;
        tick(); cmd_valid = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Monitor: pop one expected item per returned vector or poll word (R4, R11).
    always @(negedge clk) begin
        if (rst_n && (vec_valid || poll_valid)) begin
            got_item = poll_valid ? {1'b1, poll_data} : {1'b0, vec_out};
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R4 unexpected result: got %0h expected none", got_item);
            end else begin
                exp_item = exp_q.pop_front();
                chk(poll_valid ? "R11 poll word" : "R4 vector", 32'(got_item), 32'(exp_item));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 irr after reset", irr_o, 0);
        chk("R1 isr after reset", isr_o, 0);
        chk("R1 intr after reset", intr, 0);

        // R2 edge capture held after the input falls; R1 default order
        pulse(8'h28);
        chk("R2 edge held", irr_o, 8'h28);
        chk("R3 intr raised", intr, 1);
        do_ack(BASE + 3);
        chk("R4 isr after ack", isr_o, 8'h08);
        chk("R4 irr cleared", irr_o, 8'h20);
        chk("R3 lower level blocked", intr, 0);
        pulse(8'h02);
        chk("R3 higher level outranks", intr, 1);
        do_ack(BASE + 1);
        chk("R4 nested isr", isr_o, 8'h0A);

        // R6 non-specific end of service, top first
        send(3'b001, 3'd0);
        chk("R6 ns eoi top", isr_o, 8'h08);
        send(3'b001, 3'd0);
        chk("R6 ns eoi second", isr_o, 8'h00);
        chk("R3 pending now eligible", intr, 1);
        do_ack(BASE + 5);
        send(3'b010, 3'd5);
        chk("R8 idle command", isr_o, 8'h20);
        send(3'b011, 3'd5);
        chk("R6 specific eoi", isr_o, 8'h00);

        // R7 rotation commands
        send(3'b110, 3'd4);
        pulse(8'h44);
        do_ack(BASE + 6);
        chk("R7 after set lowest", intr, 0);
        send(3'b111, 3'd6);
        chk("R7 specific rotate clears", isr_o, 8'h00);
        do_ack(BASE + 2);
        send(3'b101, 3'd0);
        chk("R7 ns rotate clears", isr_o, 8'h00);
        pulse(8'h0C);
        do_ack(BASE + 3);
        chk("R7 rotated order blocks level 2", intr, 0);
        send(3'b011, 3'd3);
        do_ack(BASE + 2);
        send(3'b011, 3'd2);

        // R3 mask
        mask = 8'h01;
        pulse(8'h01);
        chk("R3 masked pending", irr_o, 8'h01);
        chk("R3 masked no intr", intr, 0);
        mask = 8'h00;
        tick();
        chk("R3 unmasked intr", intr, 1);
        do_ack(BASE + 0);
        send(3'b011, 3'd0);

        // R10 special mask mode
        pulse(8'h10);
        do_ack(BASE + 4);
        pulse(8'h80);
        chk("R10 normal blocking", intr, 0);
        special_mask = 1'b1;
        tick();
        chk("R10 special mask unblocks", intr, 1);
        do_ack(BASE + 7);
        chk("R10 both in service", isr_o, 8'h90);
        special_mask = 1'b0;
        send(3'b011, 3'd4);
        send(3'b011, 3'd7);

        // R9 automatic end of service with rotation on acknowledge (R8)
        auto_eoi = 1'b1;
        pulse(8'h20);
        do_ack(BASE + 5);
        chk("R9 auto eoi no isr", isr_o, 8'h00);
        send(3'b100, 3'd0);
        pulse(8'h48);
        do_ack(BASE + 3);
        do_ack(BASE + 6);
        pulse(8'h81);
        do_ack(BASE + 7);
        do_ack(BASE + 0);
        chk("R9 isr stays empty", isr_o, 8'h00);
        send(3'b000, 3'd0);
        pulse(8'h10);
        do_ack(BASE + 4);
        pulse(8'h44);
        do_ack(BASE + 2);   // R8 rotation off: order unchanged
        do_ack(BASE + 6);
        auto_eoi = 1'b0;

        // R11 poll
        pulse(8'h02);
        do_poll(8'h81);
        chk("R11 poll sets isr", isr_o, 8'h02);
        send(3'b011, 3'd1);
        do_poll(8'h00);
        chk("R11 empty poll no isr", isr_o, 8'h00);

        // R5 spurious acknowledge
        do_ack(BASE + 7);
        chk("R5 spurious isr", isr_o, 8'h00);
        chk("R5 spurious irr", irr_o, 8'h00);

        // R2 level mode follows the input
        tick(); level_mode = 1'b1; req_in = 8'h40;
        tick();
        chk("R2 level follows high", irr_o, 8'h40);
        chk("R3 level intr", intr, 1);
        req_in = 8'h00;
        tick();
        chk("R2 level follows low", irr_o, 8'h00);
        chk("R3 level intr drops", intr, 0);

        repeat (3) tick();
        chk("R4 results outstanding", 32'(exp_q.size()), 0);
        summary();
        $finish;
    end

endmodule